// File: doc/BRIEF.md
# Lookup-Table XOR Stream Hash

This block folds a stream of 16-bit input units into eight 32-bit state lanes. Each accepted unit picks one lane in strict rotation. The unit is XORed with the low bits of that lane, and the result indexes a table of 32-bit words. The word read from the table is then XORed back into the same lane. Adjacent units land in different lanes, so up to eight updates are free of dependencies on each other. The result still depends on the order of the input, because each lookup uses both the lane's current value and the unit.

Before use, a host fills the table through a simple write port while a load-mode input is held high. The stream is refused during load mode. A clear input sets every lane to a 32-bit seed value and restarts the lane rotation. The 256-bit digest is the concatenation of all lanes and is always on the output. A valid flag marks it as current once a unit has been absorbed. The table depth is set by a parameter: 16 index bits give the full table, and a smaller width is used in simulation.

Top module: `lutmix_hash`

## Requirements
- R1: After reset all lanes are zero, the digest is zero, `digest_valid` is low and the next accepted unit goes to lane 0.
- R2: `in_ready` is high exactly when `load_mode` and `clear` are both low.
- R3: An accepted unit u updates the selected lane s to s XOR T[i]. Here i is the low IDX_W bits of (s XOR u), and T is the table.
- R4: Accepted unit number n since reset or clear updates lane n mod 8. No other lane changes in that cycle.
- R5: The lane pointer and all lanes hold when `in_valid` is low or `in_ready` is low.
- R6: When `clear` is high at a clock edge, every lane is set to `seed`, the lane pointer goes back to lane 0 and `digest_valid` goes low. Clear takes priority over a beat.
- R7: A table write happens at a clock edge only when both `load_mode` and `tbl_we` are high. In that case T[`tbl_addr`] becomes `tbl_wdata`. A `tbl_we` pulse while `load_mode` is low leaves the table unchanged.
- R8: `digest` carries lane 7 in bits 255:224 down to lane 0 in bits 31:0.
- R9: The digest includes an accepted unit from the first cycle after its beat. `digest_valid` is high from that cycle until the next clear.
- R10: Units offered while `load_mode` is high change no lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_mode | input | 1 | Table fill mode; blocks the stream |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | IDX_W | Table write address |
| tbl_wdata | input | 32 | Table write data |
| clear | input | 1 | Set all lanes to the seed |
| seed | input | 32 | Seed value for clear |
| in_valid | input | 1 | Input unit offered |
| in_ready | output | 1 | Input unit can be taken |
| in_data | input | 16 | Input unit |
| digest | output | 256 | Lanes 7..0 concatenated |
| digest_valid | output | 1 | Digest reflects at least one absorbed unit |

## Verification
The lanes drive the digest pins directly. A wrong index, a wrong table word or a wrong lane choice therefore shows up as a digest mismatch in the very cycle after the faulty beat, and it stays there until the next clear. A stuck lane pointer shows on the beat after the one that should have moved it. A table write accepted outside load mode only becomes visible when a later lookup hits that address, so the stimulus deliberately targets that address. The reference model is compared on every clock, so any drift is caught at its first cycle.

// File: rtl/lutmix_pkg.sv
package lutmix_pkg;
  localparam int WORD_W = 32;
  localparam int UNIT_W = 16;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [UNIT_W-1:0] unit_t;
endpackage

// File: rtl/lutmix_table.sv
module lutmix_table #(
  parameter int IDX_W = 8
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_addr,
  input  lutmix_pkg::word_t     wr_data,
  input  logic [IDX_W-1:0]      rd_addr,
  output lutmix_pkg::word_t     rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  lutmix_pkg::word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/lutmix_lanes.sv
module lutmix_lanes #(
  parameter int LANES = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clear,
  input  lutmix_pkg::word_t                 seed,
  input  logic                              upd_en,
  input  logic [$clog2(LANES)-1:0]          upd_lane,
  input  lutmix_pkg::word_t                 upd_mask,
  output logic [LANES*lutmix_pkg::WORD_W-1:0] lanes_flat,
  output logic [LANES-1:0]                  lane_we
);
  localparam int W = lutmix_pkg::WORD_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lutmix_pkg::word_t q;
    assign lane_we[g] = upd_en && (upd_lane == g[$clog2(LANES)-1:0]);
    always_ff @(posedge clk) begin
      if (!rst_n)          q <= '0;
      else if (clear)      q <= seed;
      else if (lane_we[g]) q <= q ^ upd_mask;
    end
    assign lanes_flat[g*W +: W] = q;
  end
endmodule

// File: rtl/lutmix_seq.sv
module lutmix_seq #(
  parameter int LANES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      beat_fire,
  output logic [$clog2(LANES)-1:0]  lane_cnt,
  output logic                      digest_valid
);
  localparam int CW = $clog2(LANES);
  localparam logic [CW-1:0] LAST = CW'(LANES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_cnt     <= '0;
      digest_valid <= 1'b0;
    end else if (clear) begin
      lane_cnt     <= '0;
      digest_valid <= 1'b0;
    end else if (beat_fire) begin
      lane_cnt     <= (lane_cnt == LAST) ? '0 : lane_cnt + 1'b1;
      digest_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/lutmix_hash.sv
module lutmix_hash #(
  parameter int IDX_W = 8,
  parameter int LANES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_mode,
  input  logic                    tbl_we,
  input  logic [IDX_W-1:0]        tbl_addr,
  input  logic [31:0]             tbl_wdata,
  input  logic                    clear,
  input  logic [31:0]             seed,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [15:0]             in_data,
  output logic [LANES*32-1:0]     digest,
  output logic                    digest_valid
);
  localparam int W  = lutmix_pkg::WORD_W;
  localparam int CW = $clog2(LANES);

  function automatic logic [IDX_W-1:0] mix_index(lutmix_pkg::word_t s, lutmix_pkg::unit_t u);
    lutmix_pkg::word_t x;
    x = s ^ W'(u);
    return x[IDX_W-1:0];
  endfunction

  logic              beat_fire;
  logic [CW-1:0]     lane_cnt;
  logic [LANES-1:0]  lane_we;
  logic [IDX_W-1:0]  upd_idx;
  lutmix_pkg::word_t sel_state;
  lutmix_pkg::word_t tbl_word;
  logic              tbl_wr_fire;

  assign in_ready    = !load_mode && !clear;
  assign beat_fire   = in_valid && in_ready;
  assign tbl_wr_fire = load_mode && tbl_we;
  assign sel_state   = digest[lane_cnt*W +: W];
  assign upd_idx     = mix_index(sel_state, in_data);

  lutmix_table #(.IDX_W(IDX_W)) table_i (
    .clk(clk), .wr_en(tbl_wr_fire), .wr_addr(tbl_addr), .wr_data(tbl_wdata),
    .rd_addr(upd_idx), .rd_data(tbl_word)
  );

  lutmix_lanes #(.LANES(LANES)) lanes_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .seed(seed),
    .upd_en(beat_fire), .upd_lane(lane_cnt), .upd_mask(tbl_word),
    .lanes_flat(digest), .lane_we(lane_we)
  );

  lutmix_seq #(.LANES(LANES)) seq_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .beat_fire(beat_fire),
    .lane_cnt(lane_cnt), .digest_valid(digest_valid)
  );
endmodule

// File: rtl/lutmix_hash_chk.sv
module lutmix_hash_chk #(
  parameter int LANES = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clear,
  input logic [31:0]              seed,
  input logic                     load_mode,
  input logic                     in_ready,
  input logic [LANES*32-1:0]      digest,
  input logic                     digest_valid,
  input logic                     beat_fire,
  input logic [$clog2(LANES)-1:0] lane_cnt,
  input logic [LANES-1:0]         lane_we
);
  localparam int CW = $clog2(LANES);

  a_r2_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!load_mode && !clear));

  a_r4_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_we));

  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |=> (lane_cnt == (($past(lane_cnt) == CW'(LANES-1)) ? '0 : $past(lane_cnt) + 1'b1)));

  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_fire && !clear) |=> $stable(lane_cnt));

  a_r6_seeded: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (digest == {LANES{$past(seed)}}) && !digest_valid && (lane_cnt == '0));

  a_r9_valid_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |=> digest_valid);

  a_r10_load_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (load_mode && !clear) |=> $stable(digest));
endmodule

bind lutmix_hash lutmix_hash_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .clear(clear), .seed(seed), .load_mode(load_mode),
  .in_ready(in_ready), .digest(digest), .digest_valid(digest_valid),
  .beat_fire(beat_fire), .lane_cnt(lane_cnt), .lane_we(lane_we)
);

// File: tb/lutmix_hash_tb.sv
`timescale 1ns/1ps
module lutmix_hash_tb_top;
  localparam int IDX_W = 8;
  localparam int NTAB  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_mode = 1'b0, tbl_we = 1'b0, clear = 1'b0, in_valid = 1'b0;
  logic [IDX_W-1:0] tbl_addr = '0;
  logic [31:0] tbl_wdata = '0, seed = '0;
  logic [15:0] in_data = '0;
  logic in_ready, digest_valid;
  logic [255:0] digest;

  always #4 clk = ~clk;

  lutmix_hash #(.IDX_W(IDX_W), .LANES(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .clear(clear), .seed(seed),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .digest(digest), .digest_valid(digest_valid)
  );

  // behavioural model
  logic [31:0] m_tab [NTAB];
  logic [31:0] m_lane [8];
  int          m_ptr;
  bit          m_vld;
  int          n_chk = 0, n_fail = 0;
  string       tag = "R1";

  function automatic logic [255:0] m_digest();
    logic [255:0] d = '0;
    for (int k = 7; k >= 0; k--) d = {d[223:0], m_lane[k]};
    return d;
  endfunction

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: inputs already set; check ready, step model, compare after edge
  task automatic cycle();
    bit rdy;
    int idx;
    #1;
    rdy = !load_mode && !clear;
    check("R2", 256'(in_ready), 256'(rdy));
    if (clear) begin
      for (int k = 0; k < 8; k++) m_lane[k] = seed;
      m_ptr = 0; m_vld = 0;
    end else if (in_valid && rdy) begin
      idx = int'((m_lane[m_ptr] ^ {16'h0, in_data}) & (NTAB - 1));
      m_lane[m_ptr] = m_lane[m_ptr] ^ m_tab[idx];
      m_ptr = (m_ptr + 1) % 8;
      m_vld = 1;
    end
    if (load_mode && tbl_we) m_tab[tbl_addr] = tbl_wdata;
    @(posedge clk);
    @(negedge clk);
    check(tag, digest, m_digest());
    check({tag, "/R9"}, 256'(digest_valid), 256'(m_vld));
  endtask

  task automatic beat(logic [15:0] u);
    in_valid = 1'b1; in_data = u; cycle(); in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    for (int k = 0; k < 8; k++) m_lane[k] = '0;
    for (int k = 0; k < NTAB; k++) m_tab[k] = '0;
    m_ptr = 0; m_vld = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1", digest, 256'h0);
    check("R1", 256'(digest_valid), 256'h0);
    @(negedge clk);

    // R7 / R10: fill table, offering units meanwhile (must be refused)
    tag = "R10";
    load_mode = 1'b1; in_valid = 1'b1; in_data = 16'h1234;
    for (int a = 0; a < NTAB; a++) begin
      tbl_we = 1'b1; tbl_addr = IDX_W'(a);
      tbl_wdata = (32'(a) * 32'h9E37_79B1) ^ (32'(a) << 13) ^ 32'h5A5A_0F0F;
      cycle();
    end
    tbl_we = 1'b0; load_mode = 1'b0; in_valid = 1'b0;

    // R7: write strobe outside load mode ignored
    tag = "R7";
    tbl_we = 1'b1; tbl_addr = 8'h05; tbl_wdata = 32'hDEAD_BEEF; cycle();
    tbl_we = 1'b0;
    // lane0 is zero: unit 5 hits index 5 and shows the table word
    beat(16'h0005);

    // R3/R8: first lap across all lanes, distinct patterns
    tag = "R3";
    beat(16'hFFFF); beat(16'h00A5); beat(16'h8001); beat(16'h7E7E);
    tag = "R8";
    beat(16'h0100); beat(16'h00FF); beat(16'h3C3C);
    // R4: wraps to lane 0 again
    tag = "R4";
    beat(16'h0042); beat(16'h0043);

    // R5: valid low, then valid with ready blocked by clear handled below
    tag = "R5";
    in_data = 16'hAAAA; repeat (3) cycle();

    // R6: clear with seed, beat offered in same cycle (clear wins)
    tag = "R6";
    seed = 32'hC0DE_1234; clear = 1'b1; in_valid = 1'b1; in_data = 16'h0011;
    cycle();
    clear = 1'b0; in_valid = 1'b0;
    cycle();

    // R4/R5/R3: long random stream with gaps
    tag = "R4";
    for (int n = 0; n < 400; n++) begin
      in_valid = ($urandom % 3) != 0;
      in_data  = 16'($urandom);
      cycle();
    end
    in_valid = 1'b0;

    // R10: load mode again mid-stream, state must hold
    tag = "R10";
    load_mode = 1'b1; in_valid = 1'b1; repeat (4) cycle();
    load_mode = 1'b0; in_valid = 1'b0;

    // R6: clear to zero seed then single beat
    tag = "R6";
    seed = 32'h0; clear = 1'b1; cycle(); clear = 1'b0;
    tag = "R9";
    beat(16'h0007); cycle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule